// File: doc/BRIEF.md
# Clock-guess search engine for a majority-clocked three-register keystream generator

The engine takes a fixed guess for the 19-bit and 22-bit registers of a majority-clocked keystream generator, along with 64 known keystream bits. From these it recovers every value of the 23-bit register that fits the data. The top bits of the long register follow directly from the keystream, one bit per shift. Its clock-control bits cannot be derived, so the engine guesses them. Each guess is a node in a binary tree of depth 11. An 11-bit path counter, read from its top bit down, selects the branch taken at each node.

When the other two clock-control bits are equal and the long register is held, the next output bit can contradict the keystream. In that case the engine sets the counter bit for that node to 1 and replays from the root. The whole subtree is skipped, and no stack is needed.

A full candidate state is checked by running the generator on through the remaining keystream bits. If every bit matches, the state is reported. The search then continues until the counter has visited its last leaf, and a single done pulse ends it. A host drives one guess per start, and many engines can run side by side over the guess space.

Top module: `gd_search_engine`

## Requirements
- R1: The 64-bit state is packed {long[22:0], mid[21:0], short[18:0]}, with the short register in the low bits. Keystream bit i (bit i of `keystream`) is the XOR of the three register MSBs at step i. Between steps, each register advances if its clock bit (short[8], mid[10], long[10]) equals the majority of the three. The feedback taps are short 18,17,16,13; mid 21,20; long 22,21,20,7. Every state reported on `found` reproduces all 64 keystream bits under this rule.
- R2: When the guesses are the true short and mid registers of a state that produced the keystream, that state is among those reported during the search.
- R3: `found` is a one-cycle pulse per accepted candidate. `state` shows that candidate from the pulse onward and holds it until the next accepted candidate.
- R4: Each accepted start produces exactly one one-cycle `done` pulse, after the last leaf of the tree. After it, neither `done` nor `found` rises again until a new start.
- R5: `start` is ignored while a search runs. The guesses and keystream are captured only on a start seen while idle.
- R6: While reset is low, and after it is released, `done` and `found` are 0 and `state` is all zeros. A reset during a search abandons the search.
- R7: A keystream that no long-register value can explain with the given guesses ends with `done` and no `found`, and `state` keeps its previous value.
- R8: The path counter only increases during a search, and a pruning step sets only a counter bit that was 0. A search therefore ends within 2^11 × 65 cycles of its start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a search when idle |
| guess_a | input | 19 | Guessed short register at step 0 |
| guess_b | input | 22 | Guessed mid register at step 0 |
| keystream | input | 64 | Known keystream, bit i for step i |
| done | output | 1 | One-cycle pulse when the tree is exhausted |
| found | output | 1 | One-cycle pulse per accepted candidate |
| state | output | 64 | Last accepted step-0 state |

## Verification
Several properties are checked on every cycle. At least two registers move on each step. The path counter only increases, and pruning only ever sets a clear bit. Verification starts only after the eleventh shift of the long register. `done` and `found` are single-cycle pulses, and captured inputs stay frozen while a search runs. Only the bench scenarios can show that the true state is actually reached, that every reported state reproduces the keystream, that a mismatched guess reports nothing, and that a start or reset mid-search behaves as required.

// File: rtl/gd_pkg.sv
package gd_pkg;
  localparam int unsigned LA    = 19;
  localparam int unsigned LB    = 22;
  localparam int unsigned LC    = 23;
  localparam int unsigned ST_W  = LA + LB + LC;
  localparam int unsigned CB_A  = 8;
  localparam int unsigned CB_B  = 10;
  localparam int unsigned CB_C  = 10;
  localparam int unsigned DEPTH = CB_C + 1;   // guessed clock bits of the long register

  typedef logic [LA-1:0] ra_t;
  typedef logic [LB-1:0] rb_t;
  typedef logic [LC-1:0] rc_t;

  typedef enum logic [1:0] {S_IDLE, S_DET, S_VER} gd_st_e;

  function automatic ra_t adv_a(ra_t r);
    return {r[LA-2:0], r[18] ^ r[17] ^ r[16] ^ r[13]};
  endfunction

  function automatic rb_t adv_b(rb_t r);
    return {r[LB-2:0], r[21] ^ r[20]};
  endfunction

  function automatic rc_t adv_c(rc_t r);
    return {r[LC-2:0], r[22] ^ r[21] ^ r[20] ^ r[7]};
  endfunction

  // long register advanced by the full determination length in one go
  function automatic rc_t adv_c_depth(rc_t r);
    rc_t t;
    t = r;
    for (int i = 0; i < int'(DEPTH); i++) t = adv_c(t);
    return t;
  endfunction

  function automatic logic maj3(logic x, logic y, logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction
endpackage

// File: rtl/gd_clock_ctl.sv
module gd_clock_ctl
  import gd_pkg::*;
(
  input  ra_t        a,
  input  rb_t        b,
  input  logic       cb_c,
  output ra_t        a_n,
  output rb_t        b_n,
  output logic [2:0] adv
);
  logic m;
  always_comb begin
    m      = maj3(a[CB_A], b[CB_B], cb_c);
    adv[0] = (a[CB_A] == m);
    adv[1] = (b[CB_B] == m);
    adv[2] = (cb_c == m);
    a_n    = adv[0] ? adv_a(a) : a;
    b_n    = adv[1] ? adv_b(b) : b;
  end
endmodule

// File: rtl/gd_ks_window.sv
module gd_ks_window #(
  parameter int unsigned W  = 64,
  parameter int unsigned IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [W-1:0]  ks_in,
  input  logic [IW-1:0] idx,
  output logic          z_first,
  output logic          z_next,
  output logic          at_end
);
  logic [W-1:0]  ks_q;
  logic [IW-1:0] nx;

  always_ff @(posedge clk) begin
    if (!rst_n)    ks_q <= '0;
    else if (load) ks_q <= ks_in;
  end

  always_comb begin
    nx      = idx + 1'b1;
    z_first = ks_q[0];
    z_next  = ks_q[nx];
    at_end  = (idx == IW'(W - 1));
  end

  // R5: the captured keystream never changes outside a load
  a_r5_ks_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(ks_q));
endmodule

// File: rtl/gd_path_ctr.sv
module gd_path_ctr #(
  parameter int unsigned W  = 11,
  parameter int unsigned PW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  input  logic          prune,
  input  logic [PW-1:0] prune_pos,
  output logic [W-1:0]  cnt,
  output logic          full
);
  logic [W-1:0] pruned;

  // one-hot set at the contradicting node, everything below it cleared
  for (genvar i = 0; i < int'(W); i++) begin : g_dec
    logic hit, below;
    assign hit       = (prune_pos == PW'(i));
    assign below     = (prune_pos > PW'(i));
    assign pruned[i] = hit | (cnt[i] & ~below);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
    else if (prune) cnt <= pruned;
  end

  assign full = &cnt;

  // R8: the path only moves forward
  a_r8_cnt_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && (inc || prune)) |=> (cnt > $past(cnt)));
  // R8: pruning targets a branch not yet taken
  a_r8_prune_clear_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (prune && !clr && !inc) |-> !cnt[prune_pos]);
endmodule

// File: rtl/gd_search_engine.sv
module gd_search_engine
  import gd_pkg::*;
#(
  parameter int unsigned KS_BITS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LA-1:0]     guess_a,
  input  logic [LB-1:0]     guess_b,
  input  logic [KS_BITS-1:0] keystream,
  output logic              done,
  output logic              found,
  output logic [ST_W-1:0]   state
);
  localparam int unsigned KI_W = $clog2(KS_BITS);
  localparam int unsigned KW   = $clog2(DEPTH + 1);
  localparam int unsigned CW   = $clog2(LC);
  localparam int unsigned PW   = $clog2(DEPTH);

  gd_st_e          st;
  ra_t             a_w, ga_q, src_a, a_n;
  rb_t             b_w, gb_q, src_b, b_n;
  rc_t             c_w, c0, c0_nx, c_n;
  logic [KW-1:0]   k, ni;
  logic [CW-1:0]   im, it;
  logic [KI_W-1:0] kidx;
  logic            need_g, hold_cb;
  logic            done_q, found_q;
  logic [ST_W-1:0] state_q;
  logic [DEPTH-1:0] cnt;
  logic [2:0]      adv;
  logic            cnt_full, z0, z_nx, at_end, src_z0;
  logic            node_bit, cb_det, cb_in, clk_c, new_msb, c_top, contra, ver_miss;
  logic            in_det, in_ver, ld_start, det_exh, det_con, det_full;
  logic            ver_ok, ver_bad, leaf, finish, reload;

  assign in_det   = (st == S_DET);
  assign in_ver   = (st == S_VER);
  assign ld_start = (st == S_IDLE) && start;

  gd_ks_window #(.W(KS_BITS)) u_ks (
    .clk(clk), .rst_n(rst_n), .load(ld_start), .ks_in(keystream), .idx(kidx),
    .z_first(z0), .z_next(z_nx), .at_end(at_end)
  );

  gd_path_ctr #(.W(DEPTH)) u_path (
    .clk(clk), .rst_n(rst_n), .clr(ld_start), .inc(leaf && !cnt_full),
    .prune(det_con), .prune_pos(PW'(ni)), .cnt(cnt), .full(cnt_full)
  );

  gd_clock_ctl u_clk (
    .a(a_w), .b(b_w), .cb_c(cb_in), .a_n(a_n), .b_n(b_n), .adv(adv)
  );

  always_comb begin
    src_a  = (st == S_IDLE) ? guess_a      : ga_q;
    src_b  = (st == S_IDLE) ? guess_b      : gb_q;
    src_z0 = (st == S_IDLE) ? keystream[0] : z0;
    ni     = KW'(DEPTH - 1) - k;          // node index = counter bit = long-register bit guessed
    im     = CW'(LC - 2) - CW'(k);        // bit revealed by the next shift
    it     = CW'(LC - 1) - CW'(k);        // bit now at the top
    node_bit = (k < KW'(DEPTH)) ? cnt[ni] : 1'b0;
    // counter bit 0: clock bit differs from the short register's, 1: equal
    cb_det = need_g ? (node_bit ? a_w[CB_A] : ~a_w[CB_A]) : hold_cb;
    cb_in  = in_ver ? c_w[CB_C] : cb_det;
    clk_c  = adv[2];
    new_msb = a_n[LA-1] ^ b_n[LB-1] ^ z_nx;
    c_top   = c0[it];
    contra  = !clk_c && ((a_n[LA-1] ^ b_n[LB-1] ^ c_top) != z_nx);
    c0_nx = c0;
    if (need_g) c0_nx[ni]  = cb_det;
    if (clk_c)  c0_nx[im]  = new_msb;
    c_n      = clk_c ? adv_c(c_w) : c_w;
    ver_miss = (a_n[LA-1] ^ b_n[LB-1] ^ c_n[LC-1]) != z_nx;
  end

  always_comb begin
    det_exh  = in_det && at_end;
    det_con  = in_det && !at_end && contra;
    det_full = in_det && !at_end && clk_c && (k == KW'(DEPTH - 1));
    ver_ok   = in_ver && at_end;
    ver_bad  = in_ver && !at_end && ver_miss;
    leaf     = det_exh || ver_ok || ver_bad;
    finish   = leaf && cnt_full;
    reload   = ld_start || det_con || (leaf && !cnt_full);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; a_w <= '0; b_w <= '0; c_w <= '0; c0 <= '0;
      ga_q <= '0; gb_q <= '0; k <= '0; kidx <= '0; need_g <= 1'b0; hold_cb <= 1'b0;
      done_q <= 1'b0; found_q <= 1'b0; state_q <= '0;
    end else begin
      done_q  <= finish;
      found_q <= ver_ok;
      if (ver_ok) state_q <= {c0, gb_q, ga_q};
      if (ld_start) begin
        ga_q <= guess_a;
        gb_q <= guess_b;
      end
      if (reload) begin
        st      <= S_DET;
        a_w     <= src_a;
        b_w     <= src_b;
        c0      <= {src_a[LA-1] ^ src_b[LB-1] ^ src_z0, {(LC-1){1'b0}}};
        k       <= '0;
        kidx    <= '0;
        need_g  <= 1'b1;
        hold_cb <= 1'b0;
      end else if (finish) begin
        st <= S_IDLE;
      end else if (in_det) begin
        a_w     <= a_n;
        b_w     <= b_n;
        c0      <= c0_nx;
        kidx    <= kidx + 1'b1;
        need_g  <= clk_c;
        hold_cb <= cb_det;
        if (clk_c) k <= k + 1'b1;
        if (det_full) begin
          st  <= S_VER;
          c_w <= adv_c_depth(c0_nx);
        end
      end else if (in_ver) begin
        a_w  <= a_n;
        b_w  <= b_n;
        c_w  <= c_n;
        kidx <= kidx + 1'b1;
      end
    end
  end

  assign done  = done_q;
  assign found = found_q;
  assign state = state_q;

  // R1: majority rule moves at least two registers on every step
  a_r1_two_move: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |-> ($countones(adv) >= 2));
  // R2: verification starts only right after the eleventh long-register shift
  a_r2_ver_after_full: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ver && $past(in_det)) |-> ($past(clk_c) && ($past(k) == KW'(DEPTH - 1))));
  // R3: a report is a single-cycle pulse born in verification
  a_r3_found_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    found |=> !found);
  a_r3_found_from_ver: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> $past(in_ver));
  // R4: done is a single pulse issued with the engine back at idle
  a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r4_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (st == S_IDLE));
  // R5: captured guesses stay frozen while a search runs
  a_r5_guess_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |=> ($stable(ga_q) && $stable(gb_q)));
endmodule

// File: tb/gd_search_engine_tb.sv
`timescale 1ns/1ps
module gd_search_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [18:0] ga = '0;
  logic [21:0] gb = '0;
  logic [63:0] ks = '0;
  logic        done, found;
  logic [63:0] state;

  int n_chk = 0;
  int n_err = 0;

  // bit 64: keystream comes from the state with matching guesses
  localparam logic [64:0] VT [3] = '{
    {1'b1, 64'hB1E4_6C0F_D237_58A9},
    {1'b1, 64'h0F3C_A5D2_E871_4B96},
    {1'b0, 64'h5D7E_2B19_C8A4_F063}
  };

  gd_search_engine u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .guess_a(ga), .guess_b(gb),
    .keystream(ks), .done(done), .found(found), .state(state)
  );

  always #2.5 clk = ~clk;

  function automatic logic [63:0] ref_ks(input logic [63:0] s);
    logic [63:0] z;
    logic [18:0] x;
    logic [21:0] y;
    logic [22:0] w;
    logic m, mx, my, mw;
    x = s[18:0]; y = s[40:19]; w = s[63:41];
    for (int i = 0; i < 64; i++) begin
      z[i] = x[18] ^ y[21] ^ w[22];
      m  = (int'(x[8]) + int'(y[10]) + int'(w[10])) >= 2;
      mx = (x[8] == m); my = (y[10] == m); mw = (w[10] == m);
      if (mx) x = {x[17:0], ^(x & 19'h72000)};
      if (my) y = {y[20:0], ^(y & 22'h300000)};
      if (mw) w = {w[21:0], ^(w & 23'h700080)};
    end
    return z;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  task automatic run_search(input logic [63:0] st0, input bit ok_ks, input int inject_at,
                            input logic [63:0] alt, input string tag);
    logic [63:0] kv, prev_state, last;
    int cyc, nf, extra;
    bit hit, prevf, busy, dbl, bad_ks;
    kv = ref_ks(st0);
    prev_state = state;
    @(negedge clk);
    ga = st0[18:0] ^ (ok_ks ? 19'h0 : 19'h1);
    gb = st0[40:19];
    ks = kv;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0; nf = 0; hit = 0; prevf = 0; busy = 1; dbl = 0; bad_ks = 0; last = '0;
    while (busy && cyc < 140000) begin
      if (found) begin
        nf++;
        if (prevf) dbl = 1;
        if (ref_ks(state) != kv) bad_ks = 1;
        if (state == st0) hit = 1;
        last = state;
      end
      prevf = found;
      if (done) busy = 0;
      start = (inject_at != 0) && (cyc == inject_at);
      if (start) begin
        ga = alt[18:0]; gb = alt[40:19]; ks = ref_ks(alt);
      end
      if (busy) begin
        @(negedge clk);
        cyc++;
      end
    end
    start = 1'b0;
    // R8: bounded search time
    check(!busy && cyc <= 2048 * 65, {"R8 end of search ", tag}, 64'(cyc), 64'(2048 * 65));
    extra = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (done || found) extra++;
    end
    check(extra == 0, {"R4 single done, nothing after ", tag}, 64'(extra), 64'd0);
    check(!dbl, {"R3 found is one cycle ", tag}, 64'(dbl), 64'd0);
    check(!bad_ks, {"R1 reported state reproduces keystream ", tag}, 64'(bad_ks), 64'd0);
    if (ok_ks) begin
      check(hit, {"R2 true state reported ", tag}, last, st0);
      check(state == last, {"R3 state holds last report ", tag}, state, last);
    end else begin
      check(nf == 0, {"R7 no report on mismatched guess ", tag}, 64'(nf), 64'd0);
      check(state == prev_state, {"R7 state unchanged ", tag}, state, prev_state);
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL R8 watchdog actual=%0d expected=%0d", 195000, 0);
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R6: outputs at rest while in reset and just after release
    check({done, found} == 2'b00, "R6 pulses low in reset", 64'({done, found}), 64'd0);
    check(state == '0, "R6 state zero in reset", state, 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check({done, found} == 2'b00 && state == '0, "R6 quiet after release", state, 64'd0);

    for (int v = 0; v < 3; v++)
      run_search(VT[v][63:0], VT[v][64], 0, 64'h0, $sformatf("vector %0d", v));

    // R5: a start mid-search with other values is ignored
    run_search(VT[0][63:0], 1'b1, 200, VT[1][63:0], "start during search");

    // R6: reset during a search abandons it
    @(negedge clk);
    ga = VT[1][18:0]; gb = VT[1][40:19]; ks = ref_ks(VT[1][63:0]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (50) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check({done, found} == 2'b00 && state == '0, "R6 reset mid-search clears outputs", state, 64'd0);
    rst_n = 1'b1;
    begin
      int seen;
      seen = 0;
      for (int i = 0; i < 300; i++) begin
        @(negedge clk);
        if (done || found) seen++;
      end
      check(seen == 0, "R6 search abandoned after reset", 64'(seen), 64'd0);
    end

    summary();
    $finish;
  end
endmodule